// File: doc/BRIEF.md
# UART Channel FIFO Pair with Trigger-Level Interrupts

This block sits between the host bus and the serial shift registers of one UART channel. It keeps two 64-byte queues. The receive queue is filled by the receive shift register and drained by the host. The transmit queue is filled by the host and drained by the transmit shift register. A one-byte control register sets the queue behaviour:

- whether the queues are enabled;
- a one-shot flush for either queue;
- a DMA mode flag;
- two trigger-level selectors.

A separate enhanced-features input decides two things: whether the selectors may be written, and whether the selected levels are used at all.

The receive interrupt is a level compare: it is high while the receive queue holds at least the trigger count. The transmit interrupt comes from a small state machine that remembers whether the transmit queue was loaded up to its trigger since it was last empty:

- `TXI_EMPTY`: queue empty, interrupt high. It leaves to `TXI_HIGH` when the level is at or above the trigger, otherwise to `TXI_LOW`.
- `TXI_LOW`: holding bytes but never reached the trigger, interrupt low. It moves to `TXI_HIGH` on reaching the trigger and to `TXI_EMPTY` on empty.
- `TXI_HIGH`: reached the trigger, interrupt low. It moves to `TXI_REQ` when the level drops below the trigger.
- `TXI_REQ`: interrupt high. It goes back to `TXI_HIGH` when the trigger is reached again, and to `TXI_EMPTY` on empty.

Top module: `uart_fifo_trig`

## Requirements
- R1: After reset both levels are 0, the control readback `ctrl_q` is 0x00, `dma_mode` is 0, `rx_irq` is 0 and `tx_irq` is 1.
- R2: Each queue delivers bytes in push order and holds up to 64 of them. Its level output moves by +1 on an accepted push and by -1 on an accepted pop, in the cycle after the clock edge. A pop presents its byte on the data output after that edge.
- R3: A push into a full queue is dropped: the level stays put and the overrun output (`rx_ovr`/`tx_ovr`) is high in the cycle the push is presented. A pop from an empty queue leaves the level at 0 and the data output unchanged.
- R4: Control bit 1 flushes the receive queue and bit 2 flushes the transmit queue. A flush bit takes effect only when bit 0 is 1 in the same write. It reads back as 1 in `ctrl_q` for one cycle, then reads 0, and the queue level is 0 after that cycle. The other queue is untouched.
- R5: Control bit 3 drives `dma_mode`. Control bit 0 enables the queues; while it is 0, each queue accepts only one byte.
- R6: The selector fields, bits [7:6] for receive and [5:4] for transmit, are stored only by writes made while `enh_en` is 1. Other writes keep their old value, as seen in `ctrl_q`.
- R7: While `enh_en` is 0, both trigger levels are 1 whatever the stored selectors hold.
- R8: The receive trigger for selector 00/01/10/11 is 8/16/56/60. `rx_irq` is high exactly while the receive level is at or above the trigger, in the same cycle as the level.
- R9: The transmit trigger for selector 00/01/10/11 is 8/16/32/56. `tx_irq` follows the state machine above, one cycle after the level it reacts to.
- R10: If the transmit queue drains after it was last loaded without reaching its trigger, `tx_irq` stays low until the level reaches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| enh_en | input | 1 | Enhanced features on: selectors writable and used |
| host_tx_push | input | 1 | Host pushes a byte into the transmit queue |
| host_tx_data | input | 8 | Byte pushed by the host |
| sr_tx_pop | input | 1 | Transmit shift register takes a byte |
| sr_tx_data | output | 8 | Byte most recently taken from the transmit queue |
| sr_rx_push | input | 1 | Receive shift register pushes a byte |
| sr_rx_data | input | 8 | Byte pushed by the receive shift register |
| host_rx_pop | input | 1 | Host takes a byte from the receive queue |
| host_rx_data | output | 8 | Byte most recently taken from the receive queue |
| rx_level | output | 7 | Receive queue fill count |
| tx_level | output | 7 | Transmit queue fill count |
| rx_irq | output | 1 | Receive trigger interrupt |
| tx_irq | output | 1 | Transmit trigger interrupt |
| rx_ovr | output | 1 | Receive push rejected, queue full |
| tx_ovr | output | 1 | Transmit push rejected, queue full |
| dma_mode | output | 1 | DMA mode flag |
| ctrl_q | output | 8 | Control register readback |

## Verification
The receive queue is filled with a rising byte pattern right up to and past 64 entries. This shows the 60-entry trigger edge at the exact byte that reaches it, shows the dropped 65th push, and shows in-order delivery through the host-side scoreboard. The transmit queue is run with two distinct load shapes. One load climbs past the trigger, then drains, refills by one and drains again; this must raise the interrupt on the first drop below the trigger. The other load stays below the trigger; this must keep the interrupt low until the queue is empty. Writes with the enhanced input low, and flushes with the enable bit clear, tell the gated paths apart from the ones that act.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        TXI_EMPTY = 2'd0,
        TXI_LOW   = 2'd1,
        TXI_HIGH  = 2'd2,
        TXI_REQ   = 2'd3
    } txi_state_t;

    function automatic int unsigned rx_trig_of(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return 8;
            2'b01:   return 16;
            2'b10:   return 56;
            default: return 60;
        endcase
    endfunction

    function automatic int unsigned tx_trig_of(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return 8;
            2'b01:   return 16;
            2'b10:   return 32;
            default: return 56;
        endcase
    endfunction

endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [LW-1:0] cap,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [LW-1:0] level,
    output logic          ovr
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          full, empty, do_push, do_pop;

    assign full    = (level >= cap);
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign ovr     = push && full;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
            dout  <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop) begin
                rptr <= bump(rptr);
                dout <= mem[rptr];
            end
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/trig_lut.sv
module trig_lut #(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          enh_en,
    input  logic [1:0]    rx_sel,
    input  logic [1:0]    tx_sel,
    output logic [LW-1:0] rx_trig,
    output logic [LW-1:0] tx_trig
);
    import uart_fifo_pkg::*;

    always_comb begin
        if (enh_en) begin
            rx_trig = LW'(rx_trig_of(rx_sel));
            tx_trig = LW'(tx_trig_of(tx_sel));
        end else begin
            rx_trig = LW'(1);
            tx_trig = LW'(1);
        end
    end
endmodule

// File: rtl/tx_irq_fsm.sv
module tx_irq_fsm #(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] trig,
    output logic          irq
);
    import uart_fifo_pkg::*;

    txi_state_t state, nxt;
    logic       at_trig, is_empty;

    assign at_trig  = (level >= trig);
    assign is_empty = (level == '0);

    always_comb begin
        nxt = state;
        unique case (state)
            TXI_EMPTY: if (!is_empty)    nxt = at_trig ? TXI_HIGH : TXI_LOW;
            TXI_LOW:   if (is_empty)     nxt = TXI_EMPTY;
                       else if (at_trig) nxt = TXI_HIGH;
            TXI_HIGH:  if (is_empty)     nxt = TXI_EMPTY;
                       else if (!at_trig) nxt = TXI_REQ;
            TXI_REQ:   if (is_empty)     nxt = TXI_EMPTY;
                       else if (at_trig) nxt = TXI_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXI_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            TXI_EMPTY, TXI_REQ: irq = 1'b1;
            TXI_LOW, TXI_HIGH:  irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          enh_en,
    input  logic          host_tx_push,
    input  logic [DW-1:0] host_tx_data,
    input  logic          sr_tx_pop,
    output logic [DW-1:0] sr_tx_data,
    input  logic          sr_rx_push,
    input  logic [DW-1:0] sr_rx_data,
    input  logic          host_rx_pop,
    output logic [DW-1:0] host_rx_data,
    output logic [LW-1:0] rx_level,
    output logic [LW-1:0] tx_level,
    output logic          rx_irq,
    output logic          tx_irq,
    output logic          rx_ovr,
    output logic          tx_ovr,
    output logic          dma_mode,
    output logic [7:0]    ctrl_q
);
    logic          q_en, rx_fl, tx_fl, q_dma;
    logic [1:0]    rx_sel, tx_sel;
    logic [LW-1:0] cap, rx_trig, tx_trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_en   <= 1'b0;
            rx_fl  <= 1'b0;
            tx_fl  <= 1'b0;
            q_dma  <= 1'b0;
            rx_sel <= 2'b00;
            tx_sel <= 2'b00;
        end else begin
            rx_fl <= 1'b0;
            tx_fl <= 1'b0;
            if (wr_en) begin
                q_en  <= wr_data[0];
                rx_fl <= wr_data[0] & wr_data[1];
                tx_fl <= wr_data[0] & wr_data[2];
                q_dma <= wr_data[3];
                if (enh_en) begin
                    tx_sel <= wr_data[5:4];
                    rx_sel <= wr_data[7:6];
                end
            end
        end
    end

    assign ctrl_q   = {rx_sel, tx_sel, q_dma, tx_fl, rx_fl, q_en};
    assign dma_mode = q_dma;
    assign cap      = q_en ? LW'(DEPTH) : LW'(1);

    byte_queue #(.DEPTH(DEPTH), .DW(DW)) i_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_fl), .cap(cap),
        .push(sr_rx_push), .din(sr_rx_data), .pop(host_rx_pop),
        .dout(host_rx_data), .level(rx_level), .ovr(rx_ovr)
    );

    byte_queue #(.DEPTH(DEPTH), .DW(DW)) i_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_fl), .cap(cap),
        .push(host_tx_push), .din(host_tx_data), .pop(sr_tx_pop),
        .dout(sr_tx_data), .level(tx_level), .ovr(tx_ovr)
    );

    trig_lut #(.DEPTH(DEPTH)) i_lut (
        .enh_en(enh_en), .rx_sel(rx_sel), .tx_sel(tx_sel),
        .rx_trig(rx_trig), .tx_trig(tx_trig)
    );

    assign rx_irq = (rx_level >= rx_trig);

    tx_irq_fsm #(.DEPTH(DEPTH)) i_txi (
        .clk(clk), .rst_n(rst_n), .level(tx_level), .trig(tx_trig), .irq(tx_irq)
    );
endmodule

// File: rtl/uart_fifo_trig_chk.sv
module uart_fifo_trig_chk #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    ctrl_q,
    input logic [LW-1:0] rx_level,
    input logic [LW-1:0] tx_level,
    input logic          sr_rx_push,
    input logic          host_rx_pop,
    input logic [DW-1:0] host_rx_data,
    input logic          tx_irq
);
    // R2
    always_comb begin
        if (rst_n) begin
            lvl_bound_chk: assert (rx_level <= LW'(DEPTH) && tx_level <= LW'(DEPTH));
        end
    end

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rx_push && !host_rx_pop && !ctrl_q[1] && rx_level == LW'(DEPTH))
        |=> (rx_level == LW'(DEPTH)));

    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rx_pop && rx_level == '0) |=> $stable(host_rx_data));

    // R4
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[1] |=> (!ctrl_q[1] && rx_level == '0));

    // R4
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[2] |=> (!ctrl_q[2] && tx_level == '0));

    // R9
    tx_empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0) |=> tx_irq);
endmodule

bind uart_fifo_trig uart_fifo_trig_chk #(.DEPTH(DEPTH), .DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .rx_level(rx_level),
    .tx_level(tx_level), .sr_rx_push(sr_rx_push), .host_rx_pop(host_rx_pop),
    .host_rx_data(host_rx_data), .tx_irq(tx_irq)
);

// File: tb/test_uart_fifo_trig.sv
module test_uart_fifo_trig;
    localparam int CLK_NS = 10;
    localparam int DEPTH  = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, enh_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       host_tx_push = 1'b0, sr_tx_pop = 1'b0, sr_rx_push = 1'b0, host_rx_pop = 1'b0;
    logic [7:0] host_tx_data = '0, sr_rx_data = '0;
    logic [7:0] sr_tx_data, host_rx_data, ctrl_q;
    logic [6:0] rx_level, tx_level;
    logic       rx_irq, tx_irq, rx_ovr, tx_ovr, dma_mode;

    int checks = 0, errors = 0;
    int m_rx = 0, m_tx = 0, cap = 1;
    logic [7:0] last_rx = '0, last_tx = '0;
    logic [7:0] rx_q[$], tx_q[$], rx_mon[$], tx_mon[$];
    event rx_ev, tx_ev;

    always #(CLK_NS/2) clk = ~clk;

    uart_fifo_trig i_uart_fifo_trig (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0;
        cap = v[0] ? DEPTH : 1;
        check(ctrl_q[1] == (v[0] & v[1]), "R4 rx flush bit readback", ctrl_q[1], v[0] & v[1]);
        if (v[0] && (v[1] || v[2])) begin
            tick();
            if (v[1]) begin m_rx = 0; rx_q.delete(); end
            if (v[2]) begin m_tx = 0; tx_q.delete(); end
            check(ctrl_q[2:1] == 2'b00, "R4 flush bits self-clear", ctrl_q[2:1], 0);
        end
    endtask

    task automatic push_rx(input logic [7:0] b, input string req);
        sr_rx_push = 1'b1; sr_rx_data = b;
        #1;
        check(rx_ovr == (m_rx >= cap), req, rx_ovr, m_rx >= cap);
        if (m_rx < cap) begin rx_q.push_back(b); m_rx++; end
        tick();
        sr_rx_push = 1'b0;
    endtask

    task automatic pop_rx();
        host_rx_pop = 1'b1;
        if (m_rx > 0) begin last_rx = rx_q.pop_front(); m_rx--; end
        tick();
        host_rx_pop = 1'b0;
        rx_mon.push_back(last_rx);
        -> rx_ev;
    endtask

    task automatic push_tx(input logic [7:0] b, input string req);
        host_tx_push = 1'b1; host_tx_data = b;
        #1;
        check(tx_ovr == (m_tx >= cap), req, tx_ovr, m_tx >= cap);
        if (m_tx < cap) begin tx_q.push_back(b); m_tx++; end
        tick();
        host_tx_push = 1'b0;
    endtask

    task automatic pop_tx();
        sr_tx_pop = 1'b1;
        if (m_tx > 0) begin last_tx = tx_q.pop_front(); m_tx--; end
        tick();
        sr_tx_pop = 1'b0;
        tx_mon.push_back(last_tx);
        -> tx_ev;
    endtask

    initial forever begin
        @(rx_ev);
        while (rx_mon.size() > 0) begin
            logic [7:0] e;
            e = rx_mon.pop_front();
            check(host_rx_data == e, "R2 rx order", host_rx_data, e);
        end
    end

    initial forever begin
        @(tx_ev);
        while (tx_mon.size() > 0) begin
            logic [7:0] e;
            e = tx_mon.pop_front();
            check(sr_tx_data == e, "R2 tx order", sr_tx_data, e);
        end
    end

    initial begin
        #(CLK_NS * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1
        check(rx_level == 0 && tx_level == 0, "R1 levels", rx_level, 0);
        check(ctrl_q == 8'h00 && dma_mode == 1'b0, "R1 ctrl", ctrl_q, 0);
        check(rx_irq == 1'b0, "R1 rx_irq", rx_irq, 0);
        check(tx_irq == 1'b1, "R1 tx_irq", tx_irq, 1);

        // R6 selectors ignored with enh_en low; R7 trigger 1
        write_ctrl(8'hF1);
        check(ctrl_q[7:4] == 4'h0, "R6 selectors kept", ctrl_q[7:4], 0);
        push_rx(8'h11, "R3 no ovr");
        check(rx_irq == 1'b1, "R7 rx trig 1", rx_irq, 1);
        pop_rx();

        // R5 R8 selectors 11 (rx 60), dma on
        enh_en = 1'b1;
        write_ctrl(8'hC9);
        check(dma_mode == 1'b1 && ctrl_q[7:6] == 2'b11, "R5 dma and R6 write", ctrl_q, 8'hC9);
        for (int i = 0; i < 59; i++) push_rx(8'(i * 3 + 5), "R3 no ovr");
        check(rx_irq == 1'b0, "R8 below 60", rx_irq, 0);
        push_rx(8'hE0, "R3 no ovr");
        check(rx_irq == 1'b1, "R8 at 60", rx_irq, 1);
        for (int i = 0; i < 4; i++) push_rx(8'(200 + i), "R3 no ovr");
        check(rx_level == 64, "R2 full level", rx_level, 64);
        push_rx(8'h77, "R3 overrun flag");
        check(rx_level == 64, "R3 drop keeps level", rx_level, 64);
        pop_rx();
        check(rx_irq == 1'b1, "R8 63 above trig", rx_irq, 1);
        for (int i = 0; i < 4; i++) pop_rx();
        check(rx_irq == 1'b0, "R8 59 below trig", rx_irq, 0);
        while (m_rx > 0) pop_rx();
        pop_rx();
        check(rx_level == 0, "R3 empty pop level", rx_level, 0);

        // R7 default trigger with enh_en low although selectors stored 11
        enh_en = 1'b0;
        push_rx(8'h31, "R3 no ovr");
        check(rx_irq == 1'b1, "R7 default trig", rx_irq, 1);
        push_rx(8'h32, "R3 no ovr");
        push_rx(8'h33, "R3 no ovr");
        enh_en = 1'b1;

        // R4 flush gated by enable bit
        write_ctrl(8'h02);
        check(rx_level == 3, "R4 flush needs bit0", rx_level, 3);
        push_rx(8'h34, "R5 capacity one ovr");
        write_ctrl(8'h05);
        check(rx_level == 3, "R4 rx untouched by tx flush", rx_level, 3);
        write_ctrl(8'h03);
        check(rx_level == 0, "R4 rx flushed", rx_level, 0);

        // R9 transmit triggers: selector 01 -> 16
        write_ctrl(8'h11);
        tick();
        check(tx_irq == 1'b1, "R9 empty irq", tx_irq, 1);
        for (int i = 0; i < 20; i++) push_tx(8'hA0 ^ 8'(i), "R3 no ovr");
        tick();
        check(tx_irq == 1'b0, "R9 above trig", tx_irq, 0);
        for (int i = 0; i < 4; i++) pop_tx();
        tick();
        check(tx_irq == 1'b0, "R9 at trig 16", tx_irq, 0);
        pop_tx();
        tick();
        check(tx_irq == 1'b1, "R9 fell below", tx_irq, 1);
        push_tx(8'h5A, "R3 no ovr");
        tick();
        check(tx_irq == 1'b0, "R9 refilled", tx_irq, 0);
        while (m_tx > 0) pop_tx();
        tick();
        check(tx_irq == 1'b1 && tx_level == 0, "R9 drained", tx_irq, 1);

        // R10 load stays below trigger
        for (int i = 0; i < 5; i++) push_tx(8'h60 + 8'(i), "R3 no ovr");
        tick();
        check(tx_irq == 1'b0, "R10 loaded low", tx_irq, 0);
        for (int i = 0; i < 4; i++) pop_tx();
        tick();
        check(tx_irq == 1'b0, "R10 no irq below trig", tx_irq, 0);
        pop_tx();
        tick();
        check(tx_irq == 1'b1, "R10 irq on empty", tx_irq, 1);

        // R5 disabled queues accept one byte
        write_ctrl(8'h00);
        push_tx(8'h01, "R5 first accepted");
        push_tx(8'h02, "R5 second ovr");
        check(tx_level == 1, "R5 capacity one", tx_level, 1);

        tick();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule